// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block is the host end of a four-wire serial link to a read-only view of a paged flash device. A client hands it one request: a read kind (streamed array read, single-page read or on-chip buffer read), an opcode-variant select, a 9-bit page number, a 9-bit byte offset and a byte count. The block lowers chip select and shifts out the header that the chosen kind needs: opcode, address field and dummy clocks. It then clocks in exactly the requested number of bytes from the device's serial output. It raises chip select after the last data bit and signals completion with a one-cycle pulse.

Received bytes leave through a single-entry valid/ready stream. When the consumer holds ready low, the serial clock is frozen just before the edge that would complete the next byte, so no byte is dropped. A streamed array read of any length uses one header, because the device advances across page and array ends by itself. The serial clock is a fixed fraction of the system clock: each SCK level lasts `HALF` system cycles.

Top module: `sfr_host`

## Requirements
- R1: The opcode is chosen by `req_kind` and `req_alt`. Kind 2'b00 (streamed array) sends 0x68, or 0xE8 when `req_alt` is 1. Kind 2'b01 (single page) sends 0x52 or 0xD2. Kind 2'b10 (buffer) sends 0x54 or 0xD4. Kind 2'b11 is treated exactly like 2'b00.
- R2: For kinds 00, 01 and 11 the header is 64 bits, sent MSB first: the opcode, six zero bits, the 9-bit page, the 9-bit offset, then 32 zero dummy bits.
- R3: For kind 10 the header is 40 bits, sent MSB first: the opcode, fifteen zero bits, the 9-bit offset as buffer address, then eight zero bits.
- R4: `spi_mosi` changes only while `spi_sck` is low, and never at a rising SCK edge. `spi_miso` is sampled at each rising SCK edge after the header. Each byte is assembled MSB first.
- R5: Chip select stays low without a break from the first header bit to the last data bit. One transfer has exactly one header and exactly 8×count rising SCK edges after it.
- R6: Every received byte appears once on `out_data` in arrival order. While `out_valid` is high and `out_ready` is low, the byte holds stable. SCK stops before the rising edge that would complete a further byte.
- R7: `done` pulses for one cycle in the cycle in which chip select has just returned high after a transfer.
- R8: A request with `req_count` of zero gives a `done` pulse in the cycle after acceptance and never drives chip select low.
- R9: `spi_sck` is low whenever `spi_cs_n` is high, and also after reset. Outside stalls, each SCK level lasts `HALF` clock cycles.
- R10: Between any two transfers, and between reset and the first transfer, chip select stays high for at least 2×`HALF` clock cycles.
- R11: `req_ready` is low during reset, during the gap that follows reset and during every transfer and its gap. It is high only when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted on valid |
| req_kind | input | 2 | 00 streamed array, 01 single page, 10 buffer, 11 as 00 |
| req_alt | input | 1 | Use the alternate opcode |
| req_page | input | 9 | Page number (array kinds) |
| req_offset | input | 9 | Start byte within page or buffer |
| req_count | input | CNT_W | Bytes to read |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | 8 | Received byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The hardest state to reach is the back-pressure freeze. The output register must be full, and SCK must be parked low with exactly seven bits of the next byte already shifted in. The bench holds ready low from the moment a five-byte read is accepted and waits well past the header. It then checks that exactly fifteen data edges have occurred, and that all five bytes arrive intact once ready returns. A device model in the bench captures the header bits at each rising SCK edge and drives a computed byte pattern on falling edges. The sweep covers every kind, both opcode variants, corner page and offset values, several counts and random ready patterns.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
package sfr_pkg;
  localparam int HDR_MAX  = 64;
  localparam int HDR_ARR  = 64;
  localparam int HDR_BUF  = 40;
  localparam int HL_W     = $clog2(HDR_MAX + 1);
  localparam int ADDR_W   = 9;

  typedef enum logic [1:0] {
    K_STREAM = 2'b00,
    K_PAGE   = 2'b01,
    K_BUFFER = 2'b10,
    K_STREAM2 = 2'b11
  } kind_e;

  function automatic logic [7:0] pick_opcode(input logic [1:0] kind, input logic alt);
    logic [7:0] op;
    case (kind)
      K_PAGE:   op = alt ? 8'hD2 : 8'h52;
      K_BUFFER: op = alt ? 8'hD4 : 8'h54;
      default:  op = alt ? 8'hE8 : 8'h68;
    endcase
    return op;
  endfunction
endpackage

// File: rtl/sfr_header.sv
`timescale 1ns/1ps
module sfr_header
  import sfr_pkg::*;
(
  input  logic [1:0]            kind,
  input  logic                  alt,
  input  logic [ADDR_W-1:0]     page,
  input  logic [ADDR_W-1:0]     offset,
  output logic [HDR_MAX-1:0]    hdr,
  output logic [HL_W-1:0]       hlen
);
  logic [7:0] op;

  always_comb begin
    op = pick_opcode(kind, alt);
    if (kind == K_BUFFER) begin
      hdr  = {op, 15'd0, offset, 8'd0, 24'd0};
      hlen = HL_W'(HDR_BUF);
    end else begin
      hdr  = {op, 6'd0, page, offset, 32'd0};
      hlen = HL_W'(HDR_ARR);
    end
  end
endmodule

// File: rtl/sfr_tick.sv
`timescale 1ns/1ps
module sfr_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic hold,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick) begin
      if (!hold) cnt <= '0;
    end else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sfr_outq.sv
`timescale 1ns/1ps
module sfr_outq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    push |-> (!out_valid || out_ready)) else $error("byte overwritten"); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("stalled byte moved"); // R6
endmodule

// File: rtl/sfr_host.sv
`timescale 1ns/1ps
module sfr_host
  import sfr_pkg::*;
#(
  parameter int HALF  = 2,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_alt,
  input  logic [8:0]        req_page,
  input  logic [8:0]        req_offset,
  input  logic [CNT_W-1:0]  req_count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              done,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int GAP_CYC = 2 * HALF;
  localparam int GW      = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_FIN, ST_GAP} st_e;
  st_e state;

  logic [HDR_MAX-1:0] hdr_w, shreg;
  logic [HL_W-1:0]    hlen_w, bits_left;
  logic [2:0]         bit_idx;
  logic [6:0]         rxsh;
  logic [CNT_W-1:0]   bytes_left;
  logic [GW-1:0]      gap_cnt;
  logic               tick, stall, adv, push, tick_en;
  logic [7:0]         push_byte;

  sfr_header u_hdr (
    .kind(req_kind), .alt(req_alt), .page(req_page), .offset(req_offset),
    .hdr(hdr_w), .hlen(hlen_w)
  );

  // Freeze only the edge that would complete a byte while the output slot is held.
  assign stall   = (state == ST_DATA) && !spi_sck && (bit_idx == 3'd7) && out_valid && !out_ready;
  assign tick_en = (state == ST_HDR) || (state == ST_DATA) || (state == ST_FIN);

  sfr_tick #(.HALF(HALF)) u_tick (
    .clk(clk), .rst(rst), .en(tick_en), .hold(stall), .tick(tick)
  );

  assign adv       = tick && !stall;
  assign push_byte = {rxsh, spi_miso};
  assign push      = adv && (state == ST_DATA) && !spi_sck && (bit_idx == 3'd7);
  assign spi_mosi  = shreg[HDR_MAX-1];

  sfr_outq #(.W(8)) u_outq (
    .clk(clk), .rst(rst), .push(push), .din(push_byte),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      state      <= ST_GAP;
      req_ready  <= 1'b0;
      spi_cs_n   <= 1'b1;
      spi_sck    <= 1'b0;
      shreg      <= '0;
      bits_left  <= '0;
      bit_idx    <= '0;
      rxsh       <= '0;
      bytes_left <= '0;
      gap_cnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid && req_ready) begin
          if (req_count == '0) begin
            done <= 1'b1;
          end else begin
            req_ready  <= 1'b0;
            spi_cs_n   <= 1'b0;
            shreg      <= hdr_w;
            bits_left  <= hlen_w;
            bit_idx    <= '0;
            bytes_left <= req_count;
            state      <= ST_HDR;
          end
        end
        ST_HDR: if (adv) begin
          if (!spi_sck) begin
            spi_sck   <= 1'b1;
            bits_left <= bits_left - 1'b1;
          end else begin
            spi_sck <= 1'b0;
            shreg   <= shreg << 1;
            if (bits_left == '0) state <= ST_DATA;
          end
        end
        ST_DATA: if (adv) begin
          if (!spi_sck) begin
            spi_sck <= 1'b1;
            rxsh    <= push_byte[6:0];
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) begin
              bytes_left <= bytes_left - 1'b1;
              if (bytes_left == CNT_W'(1)) state <= ST_FIN;
            end
          end else begin
            spi_sck <= 1'b0;
          end
        end
        ST_FIN: if (adv) begin
          spi_sck  <= 1'b0;
          spi_cs_n <= 1'b1;
          done     <= 1'b1;
          gap_cnt  <= '0;
          state    <= ST_GAP;
        end
        ST_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GW'(GAP_CYC - 1)) begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Cycles spent with chip select high, for the gap rule.
  logic [GW:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck) else $error("sck high with cs released"); // R9
  AST_SI_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sck) |-> $stable(spi_mosi)) else $error("mosi moved at rising edge"); // R4
  AST_DONE_CS: assert property (@(posedge clk) disable iff (rst)
    done |-> spi_cs_n) else $error("done while selected"); // R7
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_count == '0) |=> (done && spi_cs_n)) else $error("zero count"); // R8
  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (hi_cnt >= (GW+1)'(GAP_CYC))) else $error("gap too short"); // R10
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (spi_cs_n && !spi_sck)) else $error("ready during transfer"); // R11
endmodule

// File: tb/sfr_host_tb.sv
`timescale 1ns/1ps
module sfr_host_tb;
  localparam int HALF = 2;
  localparam int CW   = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_alt = 1'b0, out_ready = 1'b1, spi_miso = 1'b0;
  logic [1:0] req_kind = '0;
  logic [8:0] req_page = '0, req_offset = '0;
  logic [CW-1:0] req_count = '0;
  logic req_ready, out_valid, done, spi_sck, spi_cs_n, spi_mosi;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  sfr_host #(.HALF(HALF), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_alt(req_alt), .req_page(req_page), .req_offset(req_offset),
    .req_count(req_count), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int m_hl = 64, m_seed = 0, rise_n = 0, last_rise = 0, cs_falls = 0;
  logic [63:0] cap = '0;
  logic mosi_prev = 1'b0;
  int mosi_bad = 0, sck_bad = 0, hi_run = 0, min_gap = 1000, started = 0;

  function automatic logic [7:0] pat(input int j);
    return 8'((m_seed + j * 37) & 255);
  endfunction

  always @(negedge spi_cs_n) begin
    rise_n = 0; cap = '0; cs_falls++;
  end
  always @(posedge spi_cs_n) last_rise = rise_n;
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (spi_mosi !== mosi_prev) mosi_bad++;
    if (rise_n < m_hl) cap = {cap[62:0], spi_mosi};
    rise_n++;
  end
  always @(negedge spi_sck) if (!spi_cs_n && rise_n >= m_hl) begin
    automatic int k = rise_n - m_hl;
    automatic logic [7:0] b = pat(k / 8);
    spi_miso = b[7 - (k % 8)];
  end

  // port monitors, sampled mid-cycle
  always @(negedge clk) if (!rst) begin
    mosi_prev = spi_mosi;
    if (spi_cs_n && spi_sck) sck_bad++;
    if (spi_cs_n) hi_run++;
    else begin
      if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
  end

  // ---------------- consumer ----------------
  int ready_mode = 0, rx_n = 0;
  logic [7:0] rx [0:63];
  logic [15:0] lfsr = 16'hACE1;
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
    if (out_valid && out_ready) begin
      if (rx_n < 64) rx[rx_n] = out_data;
      rx_n++;
    end
  end

  function automatic logic [7:0] exp_op(input int k, input int a);
    case (k)
      1: return a ? 8'hD2 : 8'h52;
      2: return a ? 8'hD4 : 8'h54;
      default: return a ? 8'hE8 : 8'h68;
    endcase
  endfunction

  task automatic xfer(input int k, input int a, input int pg, input int off, input int cnt, input int rm);
    logic [63:0] eh;
    logic [7:0] op;
    int f0, bad, firstbad, w;
    op = exp_op(k, a);
    m_hl = (k == 2) ? 40 : 64;
    eh = (k == 2) ? {24'd0, op, 15'd0, 9'(off), 8'd0} : {op, 6'd0, 9'(pg), 9'(off), 32'd0};
    m_seed = (pg * 3 + off + k * 11 + a) & 255;
    rx_n = 0; f0 = cs_falls;
    ready_mode = (rm == 2) ? 2 : rm;
    @(negedge clk);
    req_kind = 2'(k); req_alt = 1'(a); req_page = 9'(pg); req_offset = 9'(off);
    req_count = CW'(cnt); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (cnt == 0) begin
      chk(done === 1'b1, "R8 zero-count done", done, 1);
      repeat (20) @(negedge clk);
      chk(cs_falls == f0, "R8 zero-count cs untouched", cs_falls - f0, 0);
      return;
    end
    chk(req_ready === 1'b0, "R11 ready low in transfer", req_ready, 0);
    if (rm == 2) begin
      repeat (600) @(negedge clk);
      chk(rise_n == m_hl + 15, "R6 clock frozen under stall", rise_n - m_hl, 15);
      chk(spi_cs_n === 1'b0, "R5 cs held during stall", spi_cs_n, 0);
      ready_mode = 0;
    end
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(done === 1'b1 && spi_cs_n === 1'b1, "R7 done with cs high", {done, spi_cs_n}, 3);
    w = 0;
    while (rx_n < cnt && w < 2000) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    chk(cap == eh, (k == 2) ? "R3 buffer header" : "R2 array header", cap, eh);
    chk(cap[m_hl-1 -: 8] == op, "R1 opcode", cap[m_hl-1 -: 8], op);
    chk(cs_falls == f0 + 1, "R5 single cs window", cs_falls - f0, 1);
    chk(last_rise - m_hl == 8 * cnt, "R5 data edge count", last_rise - m_hl, 8 * cnt);
    chk(rx_n == cnt, "R6 byte count", rx_n, cnt);
    bad = 0; firstbad = -1;
    for (int j = 0; j < cnt && j < 64; j++)
      if (rx[j] !== pat(j)) begin bad++; if (firstbad < 0) firstbad = j; end
    chk(bad == 0, "R4 data bytes", (firstbad < 0) ? 0 : rx[firstbad], (firstbad < 0) ? 0 : pat(firstbad));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R9 reset idle pins", {spi_cs_n, spi_sck}, 2);
    chk(out_valid === 1'b0 && done === 1'b0, "R7 reset outputs", {out_valid, done}, 0);
    chk(req_ready === 1'b0, "R11 ready low in reset", req_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b0, "R11 ready low in post-reset gap", req_ready, 0);
    repeat (2 * HALF + 2) @(negedge clk);
    chk(req_ready === 1'b1, "R11 ready when idle", req_ready, 1);

    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 2; a++)
        for (int c = 0; c < 4; c++) begin
          automatic int pg  = (c == 0) ? 511 : (c == 1) ? 0 : (c == 2) ? (k * 97 + a) : 300;
          automatic int off = (c == 0) ? 263 : (c == 1) ? 0 : (c == 2) ? 511 : 5;
          automatic int cnt = (c == 3) ? 5 : c + 1;
          xfer(k, a, pg, off, cnt, a);
        end
    xfer(0, 0, 17, 3, 0, 0);
    xfer(2, 1, 0, 100, 0, 0);
    xfer(1, 0, 200, 250, 5, 2);
    xfer(2, 0, 0, 7, 5, 2);
    xfer(0, 1, 511, 263, 40, 1);
    xfer(3, 0, 5, 511, 40, 0);

    chk(mosi_bad == 0, "R4 mosi steady at rising edges", mosi_bad, 0);
    chk(sck_bad == 0, "R9 sck low while deselected", sck_bad, 0);
    chk(min_gap >= 2 * HALF, "R10 deselect gap", min_gap, 2 * HALF);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule